// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the serial front end of a byte-addressed nonvolatile memory that answers as an SPI slave. A host selects it with an active-low select, clocks command bytes in on the serial input, and receives read data or status on a serial output that the block drives only while it has something to send. The block decodes an opcode byte, a three-byte address and a stream of data bytes, and it reads and writes an internal byte array. It also holds a small status register with a write-enable latch and a status-lock enable bit.

The host may pause a transfer at any point with an active-low pause input. The transfer then continues where it stopped. Status writes are refused when an external lock pin is low and the lock-enable bit is set. All serial pins are sampled by a free-running system clock, so the same logic serves both SPI mode 0 and SPI mode 3.

The address counter spans `ADDR_W` bits, 18 by default, which gives a 262,144-byte space. The stored array has 2^`MEM_AW` bytes and is indexed by the low address bits, so addresses above the stored depth alias onto it.

Top module: `spi_nvram_slave`

## Requirements
- R1: While `sel_n` is high, `miso_oe` is 0 and activity on `sclk` and `mosi` changes no state, which includes the status register.
- R2: Transfers work in mode 0 (sclk idles low) and in mode 3 (sclk idles high). `mosi` is taken on rising `sclk` edges and `miso` changes after falling edges, most significant bit first.
- R3: Opcode 8'h06 sets the write-enable latch and opcode 8'h04 clears it. The first 8 rising edges after `sel_n` falls form the opcode.
- R4: Opcode 8'h05 returns the status byte, with the lock-enable at bit 7, the write-enable latch at bit 1 and all other bits 0. The byte repeats for as long as the host keeps clocking.
- R5: Opcode 8'h02, followed by a three-byte address sent MSB first (only the low 18 bits are used), writes the data bytes that follow. This happens only while the write-enable latch is set.
- R6: Opcode 8'h03 followed by an address returns data starting at that address. Opcode 8'h0B does the same after one extra dummy byte that follows the address.
- R7: The address advances by one after every data byte of a read or a write, and it wraps from 18'h3FFFF to 0.
- R8: The write-enable latch clears when `sel_n` rises at the end of any 8'h02 or 8'h01 command.
- R9: Opcode 8'h01 followed by a byte loads that byte's bit 7 into the lock-enable bit. It does so only when the latch is set and the lock is not active, the lock being active when `lock_n` is low and the lock-enable bit is 1.
- R10: While `pause_n` is low and `sel_n` is low, `miso_oe` is 0 and `sclk`/`mosi` are ignored. When `pause_n` returns high, the transfer resumes at the bit where it stopped.
- R11: If `sel_n` rises before a write data byte is complete, that partial byte is dropped. Earlier complete bytes stay written.
- R12: An unknown opcode is ignored for the rest of the selection, and `miso_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| pause_n | input | 1 | Active-low transfer pause |
| lock_n | input | 1 | Active-low status write lock |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
A wrong bit counter or phase shows up on the next byte at the latest. The read data comes back shifted or from the wrong address, or `miso_oe` is asserted during a dummy byte or an ignored command. A latch or lock-enable bit left in the wrong state is only visible through a later status read or a later write that does or does not land. For that reason, every write case is followed by a read-back of both the array and the status byte. Pauses and early deselection are checked by comparing whole bytes that straddle the interruption.

// File: rtl/spi_nvram_slave.sv
module spi_nvram_slave #(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic mosi,
  input  logic pause_n,
  input  logic lock_n,
  output logic miso,
  output logic miso_oe
);

  localparam int DEPTH = 1 << MEM_AW;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_RD, PH_WR, PH_SRD, PH_SWR, PH_IDLE
  } phase_t;

  logic [1:0] sclk_m, sel_m, mosi_m, pause_m, lock_m;
  logic sclk_d, sel_d;
  logic sclk_s, sel_s, mosi_s, pause_s, lock_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_m  <= 2'b00;
      sel_m   <= 2'b11;
      mosi_m  <= 2'b00;
      pause_m <= 2'b11;
      lock_m  <= 2'b11;
    end else begin
      sclk_m  <= {sclk_m[0], sclk};
      sel_m   <= {sel_m[0], sel_n};
      mosi_m  <= {mosi_m[0], mosi};
      pause_m <= {pause_m[0], pause_n};
      lock_m  <= {lock_m[0], lock_n};
    end

  assign sclk_s  = sclk_m[1];
  assign sel_s   = sel_m[1];
  assign mosi_s  = mosi_m[1];
  assign pause_s = pause_m[1];
  assign lock_s  = lock_m[1];

  phase_t phase;
  logic [2:0] bit_cnt;
  logic [1:0] abyte;
  logic [6:0] sr;
  logic [15:0] addr_hi;
  logic [ADDR_W-1:0] addr;
  logic wr_mode, fast, wr_cmd, wel, guard, miso_q;
  logic [7:0] mem [DEPTH];

  logic active, rise, fall, sel_rise, byte_done;
  logic [7:0] rx_byte, status, rd_byte;

  assign active    = !sel_s && pause_s;
  assign rise      = active && sclk_s && !sclk_d;
  assign fall      = active && !sclk_s && sclk_d;
  assign sel_rise  = sel_s && !sel_d;
  assign rx_byte   = {sr, mosi_s};
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign status    = {guard, 5'b00000, wel, 1'b0};
  assign rd_byte   = (phase == PH_SRD) ? status : mem[addr[MEM_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sel_d   <= 1'b1;
      phase   <= PH_OPC;
      bit_cnt <= 3'd0;
      abyte   <= 2'd0;
      sr      <= 7'd0;
      addr_hi <= 16'd0;
      addr    <= '0;
      wr_mode <= 1'b0;
      fast    <= 1'b0;
      wr_cmd  <= 1'b0;
      wel     <= 1'b0;
      guard   <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_s;
      if (sel_s) begin
        phase   <= PH_OPC;
        bit_cnt <= 3'd0;
        abyte   <= 2'd0;
        wr_cmd  <= 1'b0;
      end
      if (sel_rise && wr_cmd) wel <= 1'b0;
      if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        sr      <= rx_byte[6:0];
      end
      if (byte_done) begin
        case (phase)
          PH_OPC: begin
            phase <= PH_IDLE;
            case (rx_byte)
              8'h06: wel <= 1'b1;
              8'h04: wel <= 1'b0;
              8'h05: phase <= PH_SRD;
              8'h01: begin phase <= PH_SWR; wr_cmd <= 1'b1; end
              8'h02: begin phase <= PH_ADDR; wr_cmd <= 1'b1; wr_mode <= 1'b1; fast <= 1'b0; end
              8'h03: begin phase <= PH_ADDR; wr_mode <= 1'b0; fast <= 1'b0; end
              8'h0B: begin phase <= PH_ADDR; wr_mode <= 1'b0; fast <= 1'b1; end
              default: ;
            endcase
          end
          PH_ADDR: begin
            abyte   <= abyte + 2'd1;
            addr_hi <= {addr_hi[7:0], rx_byte};
            if (abyte == 2'd2) begin
              addr  <= ADDR_W'({addr_hi, rx_byte});
              phase <= wr_mode ? PH_WR : (fast ? PH_DUMMY : PH_RD);
            end
          end
          PH_DUMMY: phase <= PH_RD;
          PH_RD, PH_WR: addr <= addr + ADDR_W'(1);
          PH_SWR: begin
            if (wel && (lock_s || !guard)) guard <= rx_byte[7];
            phase <= PH_IDLE;
          end
          default: ;
        endcase
      end
      if (fall) miso_q <= rd_byte[~bit_cnt];
    end

  always_ff @(posedge clk)
    if (byte_done && phase == PH_WR && wel) mem[addr[MEM_AW-1:0]] <= rx_byte;

  assign miso    = miso_q;
  assign miso_oe = active && (phase == PH_RD || phase == PH_SRD);

  assert_idle_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && sel_d) |=> ($stable(wel) && $stable(guard)));

  assert_pause_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && !pause_s) |=> ($stable(bit_cnt) && $stable(phase)));

  assert_latch_set_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(sel_s) == 1'b0));

  assert_guard_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (guard != $past(guard)) |-> ($past(wel) && ($past(lock_s) || !$past(guard))));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_RD || phase == PH_WR)) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: tb/tb_spi_nvram_slave.sv
module tb_spi_nvram_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  typedef struct packed {
    logic [1:0]  op;
    logic        m3;
    logic [17:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 18'h00010, 8'hA5},
    '{2'd0, 1'b1, 18'h00011, 8'h3C},
    '{2'd1, 1'b0, 18'h00010, 8'hA5},
    '{2'd1, 1'b1, 18'h00011, 8'h3C},
    '{2'd2, 1'b0, 18'h00010, 8'hA5},
    '{2'd0, 1'b0, 18'h2ABCD, 8'h5A},
    '{2'd2, 1'b1, 18'h2ABCD, 8'h5A},
    '{2'd1, 1'b0, 18'h00011, 8'h3C}
  };

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sclk = 0, mosi = 0, pause_n = 1, lock_n = 1;
  logic miso, miso_oe;
  logic m3 = 0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  spi_nvram_slave dut (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
    .mosi(mosi), .pause_n(pause_n), .lock_n(lock_n), .miso(miso), .miso_oe(miso_oe));

  always #(CLK_P/2) clk = ~clk;

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic r);
    sclk = 0; mosi = b; wait_clk(HALF);
    r = miso; sclk = 1; wait_clk(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(tx[i], r); rx[i] = r; end
  endtask

  task automatic sel();
    sclk = m3; wait_clk(HALF); sel_n = 0; wait_clk(HALF);
  endtask

  task automatic desel();
    if (!m3) begin sclk = 0; wait_clk(HALF); end
    sel_n = 1; wait_clk(2*HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xbyte(op, d); desel();
  endtask

  task automatic send_addr(input logic [17:0] a);
    logic [7:0] d;
    xbyte({6'd0, a[17:16]}, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    sel(); xbyte(8'h05, d); xbyte(8'h00, s); desel();
  endtask

  task automatic wr_mem(input logic [17:0] a, input logic [7:0] v, input logic en);
    logic [7:0] d;
    if (en) cmd1(8'h06);
    sel(); xbyte(8'h02, d); send_addr(a); xbyte(v, d); desel();
  endtask

  task automatic rd_mem(input logic [17:0] a, input logic fst, output logic [7:0] v);
    logic [7:0] d;
    sel(); xbyte(fst ? 8'h0B : 8'h03, d); send_addr(a);
    if (fst) xbyte(8'h00, d);
    xbyte(8'h00, v); desel();
  endtask

  task automatic wr_status(input logic [7:0] v, input logic en);
    logic [7:0] d;
    if (en) cmd1(8'h06);
    sel(); xbyte(8'h01, d); xbyte(v, d); desel();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d, s, r;
    logic b;
    wait_clk(3);
    chk("R1 oe in reset", {7'd0, miso_oe}, 8'h00);
    rst_n = 1; wait_clk(4);
    rd_status(s); chk("R4 status after reset", s, 8'h00);

    for (int i = 0; i < 6; i++) begin
      sclk = 0; mosi = (i >= 5) ? 1'b1 : 1'b0; wait_clk(HALF); sclk = 1; wait_clk(HALF);
      chk("R1 oe while deselected", {7'd0, miso_oe}, 8'h00);
    end
    sclk = 0; wait_clk(HALF);
    rd_status(s); chk("R1 standby ignores clock", s, 8'h00);

    cmd1(8'h06); rd_status(s); chk("R3 set latch, R4 bit 1", s, 8'h02);
    cmd1(8'h04); rd_status(s); chk("R3 clear latch", s, 8'h00);

    for (int k = 0; k < 8; k++) begin
      m3 = VEC[k].m3;
      if (VEC[k].op == 2'd0) wr_mem(VEC[k].addr, VEC[k].data, 1'b1);
      else begin
        rd_mem(VEC[k].addr, VEC[k].op == 2'd2, d);
        chk($sformatf("R6 R2 vector %0d", k), d, VEC[k].data);
      end
    end
    m3 = 0;

    wr_mem(18'h00010, 8'hFF, 1'b0);
    rd_mem(18'h00010, 1'b0, d); chk("R5 write without latch", d, 8'hA5);

    cmd1(8'h06);
    sel(); xbyte(8'h02, d); send_addr(18'h3FFFF);
    xbyte(8'h11, d); xbyte(8'h22, d); xbyte(8'h33, d); desel();
    rd_status(s); chk("R8 latch cleared after write", s, 8'h00);
    sel(); xbyte(8'h03, d); send_addr(18'h3FFFF);
    xbyte(8'h00, d); chk("R7 burst byte 0", d, 8'h11);
    xbyte(8'h00, d); chk("R7 wrap byte 1", d, 8'h22);
    xbyte(8'h00, d); chk("R7 wrap byte 2", d, 8'h33);
    desel();
    rd_mem(18'h00000, 1'b0, d); chk("R7 wrap landed at 0", d, 8'h22);

    wr_status(8'h80, 1'b0); rd_status(s); chk("R9 no latch no update", s, 8'h00);
    wr_status(8'h80, 1'b1); rd_status(s); chk("R9 R8 guard set latch clear", s, 8'h80);
    sel(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, r); desel();
    chk("R4 status repeats", r, 8'h80);
    lock_n = 0;
    wr_status(8'h00, 1'b1); rd_status(s); chk("R9 locked status write", s, 8'h80);
    lock_n = 1;
    wr_status(8'h00, 1'b1); rd_status(s); chk("R9 unlocked status write", s, 8'h00);

    wr_mem(18'h00020, 8'hC6, 1'b1);
    sel(); xbyte(8'h03, d); send_addr(18'h00020);
    for (int i = 7; i >= 4; i--) begin bit_io(1'b0, b); d[i] = b; end
    sclk = 0; wait_clk(HALF); pause_n = 0; wait_clk(HALF);
    chk("R10 oe during pause", {7'd0, miso_oe}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      sclk = 1; mosi = 1; wait_clk(HALF); sclk = 0; mosi = 0; wait_clk(HALF);
    end
    pause_n = 1; wait_clk(HALF);
    for (int i = 3; i >= 0; i--) begin bit_io(1'b0, b); d[i] = b; end
    desel();
    chk("R10 byte across pause", d, 8'hC6);

    wr_mem(18'h00041, 8'h99, 1'b1);
    cmd1(8'h06);
    sel(); xbyte(8'h02, d); send_addr(18'h00040); xbyte(8'h77, d);
    for (int i = 0; i < 5; i++) bit_io(1'b0, b);
    desel();
    sel(); xbyte(8'h03, d); send_addr(18'h00040);
    xbyte(8'h00, d); chk("R11 complete byte kept", d, 8'h77);
    xbyte(8'h00, d); chk("R11 partial byte dropped", d, 8'h99);
    desel();
    chk("R1 oe after deselect", {7'd0, miso_oe}, 8'h00);

    sel(); xbyte(8'hAA, d);
    for (int i = 0; i < 4; i++) bit_io(1'b0, b);
    chk("R12 unknown opcode oe", {7'd0, miso_oe}, 8'h00);
    desel();
    rd_status(s); chk("R12 status unchanged", s, 8'h00);

    finish_run();
  end
endmodule